// File: doc/BRIEF.md
# T1 Channel Extractor for a 32-Slot Serial Backplane

This block sits on the transmit side of a T1 line interface whose system bus runs at 2.048 MHz. The backplane frame has 32 timeslots of 8 bits, which is 256 bit clocks. Only 24 of those slots carry T1 payload. The block counts bit and slot positions and drops every fourth slot, starting with slot 0. It numbers the 24 remaining slots as T1 channels 1 to 24. Each completed channel byte is presented with a one-clock valid strobe and its channel number.

A channel-block output goes high during every dropped slot, so that downstream logic can see where the backplane carries no T1 data. A sync input realigns the counters to the start of a frame. A mode input sets how that pulse is read. In frame mode the pulse only realigns the position. In multiframe mode it also restarts a frame counter, which otherwise wraps after a configurable number of frames.

Top module: `t1_slot_mapper`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, byte_vld is 0, frame_idx is 0 and chan_blk is 1, because the position is bit 0 of slot 0.
- R2: The position advances by one bit on every clock. Slots are 8 bits long and a frame has 32 slots, so 256 clocks later the position returns to bit 0 of slot 0.
- R3: chan_blk is 1 for all 8 clocks of every slot whose number is a multiple of 4 (0, 4, 8, ... 28), and 0 during all other slots.
- R4: Data received in a slot with chan_blk high never produces a byte_vld and never reaches byte_out.
- R5: For every other slot s, byte_vld is 1 in the clock that follows the slot's eighth bit. byte_out then holds the slot's 8 bits, with the first bit received in bit 7. chan_idx holds s - floor(s/4), which runs 1 to 24 in slot order.
- R6: byte_vld never stays high for two clocks in a row. A frame that runs without a misaligned sync produces exactly 24 strobes.
- R7: When sync_in is 1 at a clock edge, the next clock is bit 0 of slot 0. The bit presented in the sync clock is still handled at its old position.
- R8: frame_idx increments each time the position returns to slot 0 bit 0, whether by wrapping or by a sync in frame mode (sync_mode=0). It wraps from MF_FRAMES-1 (default 11) to 0.
- R9: In multiframe mode (sync_mode=1), a sync sets frame_idx to 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0: sync pulse is a frame sync, 1: multiframe sync |
| sync_in | input | 1 | Sync pulse; the next clock is slot 0 bit 0 |
| ser_in | input | 1 | Serial backplane data, MSB of each slot first |
| chan_blk | output | 1 | High during dropped slots |
| byte_vld | output | 1 | One-clock strobe for a completed channel byte |
| byte_out | output | 8 | Completed channel byte |
| chan_idx | output | 5 | T1 channel number 1..24 of byte_out |
| frame_idx | output | 4 | Frame counter within the multiframe |

## Verification
The bound assertions check the timing rules on every cycle. A sync always lands the counters on slot 0 bit 0. Channel numbers stay within 1 to 24. The strobe never lasts two clocks. A rising chan_blk falls on a slot boundary. A multiframe sync clears the frame counter, and the frame counter stays within range. The values themselves can only be shown by the bench scenarios: which bits end up in which channel byte, that dropped slots contribute nothing, and that an undisturbed frame yields exactly 24 bytes. The bench runs aligned syncs, free-running frames, multiframe syncs and random misaligned syncs against its own position model.

// File: rtl/t1_slot_mapper.sv
module t1_slot_mapper #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 32,
  parameter int SKIP      = 4,
  parameter int MF_FRAMES = 12,
  localparam int CHANS    = SLOTS - SLOTS / SKIP,
  localparam int CW       = $clog2(CHANS + 1),
  localparam int FW       = $clog2(MF_FRAMES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_mode,
  input  logic                 sync_in,
  input  logic                 ser_in,
  output logic                 chan_blk,
  output logic                 byte_vld,
  output logic [SLOT_BITS-1:0] byte_out,
  output logic [CW-1:0]        chan_idx,
  output logic [FW-1:0]        frame_idx
);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(SLOTS);
  localparam logic [BW-1:0] BIT_LAST   = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SLOT_LAST  = SW'(SLOTS - 1);
  localparam logic [SW-1:0] SKIP_W     = SW'(SKIP);
  localparam logic [FW-1:0] FRAME_LAST = FW'(MF_FRAMES - 1);

  logic [BW-1:0]        bit_q;
  logic [SW-1:0]        slot_q;
  logic [SLOT_BITS-1:0] sh_q;

  wire skip_slot = (slot_q % SKIP_W) == '0;
  wire last_bit  = bit_q == BIT_LAST;
  wire wrap      = last_bit && (slot_q == SLOT_LAST);
  wire restart   = sync_in || wrap;
  wire take      = last_bit && !skip_slot;
  wire [SLOT_BITS-1:0] sh_next = {sh_q[SLOT_BITS-2:0], ser_in};

  assign chan_blk = skip_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      slot_q    <= '0;
      sh_q      <= '0;
      frame_idx <= '0;
      byte_vld  <= 1'b0;
      byte_out  <= '0;
      chan_idx  <= '0;
    end else begin
      sh_q <= sh_next;
      if (restart) begin
        bit_q  <= '0;
        slot_q <= '0;
      end else if (last_bit) begin
        bit_q  <= '0;
        slot_q <= slot_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
      if (sync_in && sync_mode)
        frame_idx <= '0;
      else if (restart)
        frame_idx <= (frame_idx == FRAME_LAST) ? '0 : frame_idx + 1'b1;
      byte_vld <= take;
      if (take) begin
        byte_out <= sh_next;
        chan_idx <= CW'(slot_q - slot_q / SKIP_W);
      end
    end
  end
endmodule

// File: rtl/t1_slot_mapper_chk.sv
module t1_slot_mapper_chk #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 32,
  parameter int SKIP      = 4,
  parameter int MF_FRAMES = 12,
  localparam int CHANS    = SLOTS - SLOTS / SKIP,
  localparam int CW       = $clog2(CHANS + 1),
  localparam int FW       = $clog2(MF_FRAMES),
  localparam int BW       = $clog2(SLOT_BITS),
  localparam int SW       = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_mode,
  input logic          sync_in,
  input logic          chan_blk,
  input logic          byte_vld,
  input logic [CW-1:0] chan_idx,
  input logic [FW-1:0] frame_idx,
  input logic [BW-1:0] bit_q,
  input logic [SW-1:0] slot_q
);
  p_sync_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (bit_q == '0 && slot_q == '0));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (chan_idx >= CW'(1) && chan_idx <= CW'(CHANS)));

  p_vld_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  p_blk_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_blk) |-> bit_q == '0);

  p_mf_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && sync_mode) |=> frame_idx == '0);

  p_frame_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx <= FW'(MF_FRAMES - 1));
endmodule

bind t1_slot_mapper t1_slot_mapper_chk #(
  .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .SKIP(SKIP), .MF_FRAMES(MF_FRAMES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sync_in(sync_in),
  .chan_blk(chan_blk), .byte_vld(byte_vld), .chan_idx(chan_idx),
  .frame_idx(frame_idx), .bit_q(bit_q), .slot_q(slot_q)
);

// File: tb/t1_slot_mapper_tb_top.sv
module t1_slot_mapper_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic sync_in = 1'b0;
  logic ser_in = 1'b0;
  logic       chan_blk, byte_vld;
  logic [7:0] byte_out;
  logic [4:0] chan_idx;
  logic [3:0] frame_idx;

  t1_slot_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sync_in(sync_in),
    .ser_in(ser_in), .chan_blk(chan_blk), .byte_vld(byte_vld),
    .byte_out(byte_out), .chan_idx(chan_idx), .frame_idx(frame_idx)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int m_bit = 0, m_slot = 0, m_frame = 0;
  logic [7:0] m_sh = '0, e_byte = '0;
  int e_idx = 0;
  bit e_vld = 1'b0;
  int vcnt = 0;
  bit clean = 1'b0;

  function automatic bit is_skip(int s); return (s % 4) == 0; endfunction
  function automatic int chan_of(int s); return s - s / 4; endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_update(input logic s, input logic m, input logic d);
    sync_in = s; sync_mode = m; ser_in = d;
    e_vld = (m_bit == 7) && !is_skip(m_slot);
    if (e_vld) begin
      e_byte = {m_sh[6:0], d};
      e_idx  = chan_of(m_slot);
    end
    m_sh = {m_sh[6:0], d};
    if (s && !(m_bit == 7 && m_slot == 31)) clean = 1'b0;
    if (s) begin
      m_bit = 0; m_slot = 0;
      m_frame = m ? 0 : (m_frame + 1) % 12;
    end else if (m_bit == 7) begin
      m_bit = 0;
      if (m_slot == 31) begin m_slot = 0; m_frame = (m_frame + 1) % 12; end
      else m_slot++;
    end else m_bit++;
  endtask

  task automatic cyc(input logic s, input logic m, input logic d);
    @(negedge clk);
    check("R3 R7 chan_blk", chan_blk, is_skip(m_slot));
    check("R4 R5 R6 byte_vld", byte_vld, e_vld);
    if (e_vld && byte_vld) begin
      check("R5 byte_out", byte_out, e_byte);
      check("R5 chan_idx", chan_idx, e_idx);
    end
    check("R8 R9 frame_idx", frame_idx, m_frame);
    if (byte_vld) vcnt++;
    if (m_bit == 0 && m_slot == 0) begin
      if (clean) check("R2 R6 strobes per frame", vcnt, 24);
      vcnt = 0; clean = 1'b1;
    end
    drive_update(s, m, d);
  endtask

  task automatic frames(input int n, input logic m, input bit sync_end);
    for (int i = 0; i < n * 256; i++)
      cyc(sync_end && m_bit == 7 && m_slot == 31, m, 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 byte_vld in reset", byte_vld, 0);
    check("R1 frame_idx in reset", frame_idx, 0);
    check("R1 chan_blk in reset", chan_blk, 1);
    rst_n = 1'b1;
    drive_update(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 byte_vld after reset", byte_vld, 0);
    check("R1 frame_idx after reset", frame_idx, 0);
    drive_update(1'b0, 1'b0, 1'b1);
    // aligned frame sync, then free running (R2 R8)
    frames(4, 1'b0, 1'b1);
    frames(3, 1'b0, 1'b0);
    // skipped slots all ones, payload zero (R4)
    for (int i = 0; i < 512; i++) cyc(1'b0, 1'b0, is_skip(m_slot));
    // multiframe sync every 12 frames, plus one early (R9)
    for (int f = 0; f < 26; f++) begin
      if (f == 5) begin
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b1, 1'($urandom));
        cyc(1'b1, 1'b1, 1'($urandom));
      end
      frames(1, 1'b1, (f % 12) == 11);
    end
    // misaligned frame sync mid slot (R7)
    for (int i = 0; i < 37; i++) cyc(1'b0, 1'b0, 1'($urandom));
    cyc(1'b1, 1'b0, 1'b1);
    frames(2, 1'b0, 1'b0);
    // random syncs and modes
    for (int i = 0; i < 20 * 256; i++)
      cyc(($urandom % 300) == 0, 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end
endmodule